// File: doc/BRIEF.md
# Bidirectional IPC Doorbell Register Block

This block gives a host processor and an embedded DSP a pair of independent, register-mapped mailboxes for short messages. Each side has its own register port with a 3-bit register select, a write strobe, write data and combinational read data. The host-to-DSP path (initiator) holds a primary word, an extension word and an acknowledge flag. The DSP-to-host path (target) holds a primary word, an extension word and an acknowledge flag of its own.

The host posts a message by writing the extension word and then the primary word with its top bit set. That write raises a doorbell line toward the DSP. The DSP consumes the message and answers with a DONE flag. For the reverse path the DSP posts a target primary word with its top bit set. The host accepts it with a write-one-to-clear and then releases the target acknowledge with a write-zero. A control register holds one interrupt enable for each host-facing event and a sticky overrun flag. The host interrupt is a level built from these bits. The asynchronous reset is released through a two-stage synchronizer.

Register selects, shared by both ports: 0 initiator primary, 1 initiator extension, 2 initiator acknowledge, 3 target primary, 4 target extension, 5 target acknowledge, 6 control (host port only; reads 0 on the DSP port), 7 reads 0. With the default 32-bit width, BUSY is bit 31 of a primary word and of the target acknowledge, DONE is bit 30 of the initiator acknowledge, and the primary payload is bits 30:0.

Top module: `ipc_doorbell`

## Requirements
- R1: After reset every BUSY, DONE and overrun flag is clear, both enables are clear, all registers read 0 on both ports, and `host_irq` and `dsp_doorbell` are low.
- R2: A host write to select 0 with bit 31 set, made while initiator BUSY is clear, stores bits 30:0 as the payload and sets BUSY. `dsp_doorbell` goes high, and the DSP reads select 0 as BUSY plus the payload and select 1 as the extension last written. A host primary write with bit 31 clear changes nothing.
- R3: While initiator BUSY is set, host writes to select 0 and select 1 leave both words unchanged. A primary write with bit 31 set also sets the sticky overrun flag (control bit 2). The flag is cleared only by a host control write with bit 2 set.
- R4: A DSP write to select 2 with bit 30 set sets DONE (read at bit 30) and clears initiator BUSY. A host write to select 2 with bit 30 set clears DONE, and a host write with bit 30 clear leaves it unchanged. If the DSP sets DONE and the host clears it in the same cycle, DONE ends up set.
- R5: A DSP write to select 3 with bit 31 set, made while target BUSY is clear, stores bits 30:0 unchanged, including direction bit 29. It also sets target BUSY and target acknowledge bit 31. While target BUSY is set, DSP writes to select 3 and select 4 are ignored.
- R6: A host write to select 3 with bit 31 set clears target BUSY and leaves the payload readable. A write with bit 31 clear has no effect.
- R7: A host write to select 5 with bit 31 clear clears the target acknowledge flag, which both ports see. A write with bit 31 set has no effect.
- R8: Control bit 0 enables the inbound (target BUSY) interrupt and bit 1 enables the DONE interrupt. `host_irq` equals (target BUSY AND bit 0) OR (DONE AND bit 1), with no cycle of added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_addr | input | 3 | Host register select |
| hst_wdata | input | DATA_W | Host write data |
| hst_we | input | 1 | Host write strobe |
| hst_rdata | output | DATA_W | Host read data for the selected register |
| dsp_addr | input | 3 | DSP register select |
| dsp_wdata | input | DATA_W | DSP write data |
| dsp_we | input | 1 | DSP write strobe |
| dsp_rdata | output | DATA_W | DSP read data for the selected register |
| host_irq | output | 1 | Level interrupt to the host |
| dsp_doorbell | output | 1 | High while a host message waits for the DSP |

## Verification
The bench targets the places where the clearing rules differ. A design that treated the target acknowledge as write-one-to-clear would keep it set after the host's write of zero. A design that let the host's DONE clear win over the DSP's same-cycle set would lose an acknowledge. A second send while BUSY must leave the first payload intact and latch overrun; a design that overwrote it would corrupt a message the DSP has not yet read. The bench sweeps every combination of the two enables against the two pending events to catch a swapped or missing interrupt term.

// File: rtl/ipc_doorbell_pkg.sv
package ipc_doorbell_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_INI_PRI = 3'd0,
    SEL_INI_EXT = 3'd1,
    SEL_INI_ACK = 3'd2,
    SEL_TGT_PRI = 3'd3,
    SEL_TGT_EXT = 3'd4,
    SEL_TGT_ACK = 3'd5,
    SEL_CTRL    = 3'd6,
    SEL_NONE    = 3'd7
  } reg_sel_e;

  localparam int CTRL_EN_BUSY = 0;
  localparam int CTRL_EN_DONE = 1;
  localparam int CTRL_OVR     = 2;
endpackage

// File: rtl/dbl_rst_sync.sv
module dbl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/dbl_ini_lane.sv
module dbl_ini_lane #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_pri_we,
  input  logic              h_ext_we,
  input  logic              h_ack_we,
  input  logic [DATA_W-1:0] h_wdata,
  input  logic              d_ack_we,
  input  logic [DATA_W-1:0] d_wdata,
  input  logic              ovr_clr,
  output logic              busy_o,
  output logic              done_o,
  output logic              ovr_o,
  output logic [DATA_W-2:0] pay_o,
  output logic [DATA_W-1:0] ext_o
);
  localparam int BUSY_B = DATA_W - 1;
  localparam int DONE_B = DATA_W - 2;

  logic              busy_q, busy_d, done_q, done_d, ovr_q, ovr_d;
  logic              pay_en, ext_en;
  logic [DATA_W-2:0] pay_q;
  logic [DATA_W-1:0] ext_q;

  always_comb begin
    busy_d = busy_q;
    done_d = done_q;
    ovr_d  = ovr_q;
    pay_en = 1'b0;
    ext_en = h_ext_we && !busy_q;
    if (ovr_clr) ovr_d = 1'b0;
    if (h_pri_we && h_wdata[BUSY_B]) begin
      if (busy_q) begin
        ovr_d = 1'b1;
      end else begin
        busy_d = 1'b1;
        pay_en = 1'b1;
      end
    end
    if (h_ack_we && h_wdata[DONE_B]) done_d = 1'b0;
    if (d_ack_we && d_wdata[DONE_B]) begin
      done_d = 1'b1;
      if (busy_q) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      ovr_q  <= 1'b0;
      pay_q  <= '0;
      ext_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      ovr_q  <= ovr_d;
      if (pay_en) pay_q <= h_wdata[BUSY_B-1:0];
      if (ext_en) ext_q <= h_wdata;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign ovr_o  = ovr_q;
  assign pay_o  = pay_q;
  assign ext_o  = ext_q;
endmodule

// File: rtl/dbl_tgt_lane.sv
module dbl_tgt_lane #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              d_pri_we,
  input  logic              d_ext_we,
  input  logic [DATA_W-1:0] d_wdata,
  input  logic              h_pri_we,
  input  logic              h_ack_we,
  input  logic [DATA_W-1:0] h_wdata,
  output logic              busy_o,
  output logic              ack_o,
  output logic [DATA_W-2:0] pay_o,
  output logic [DATA_W-1:0] ext_o
);
  localparam int BUSY_B = DATA_W - 1;

  logic              busy_q, busy_d, ack_q, ack_d;
  logic              pay_en, ext_en;
  logic [DATA_W-2:0] pay_q;
  logic [DATA_W-1:0] ext_q;

  always_comb begin
    busy_d = busy_q;
    ack_d  = ack_q;
    pay_en = d_pri_we && d_wdata[BUSY_B] && !busy_q;
    ext_en = d_ext_we && !busy_q;
    if (h_pri_we && h_wdata[BUSY_B]) busy_d = 1'b0;
    if (h_ack_we && !h_wdata[BUSY_B]) ack_d = 1'b0;
    if (pay_en) begin
      busy_d = 1'b1;
      ack_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ack_q  <= 1'b0;
      pay_q  <= '0;
      ext_q  <= '0;
    end else begin
      busy_q <= busy_d;
      ack_q  <= ack_d;
      if (pay_en) pay_q <= d_wdata[BUSY_B-1:0];
      if (ext_en) ext_q <= d_wdata;
    end
  end

  assign busy_o = busy_q;
  assign ack_o  = ack_q;
  assign pay_o  = pay_q;
  assign ext_o  = ext_q;
endmodule

// File: rtl/ipc_doorbell.sv
module ipc_doorbell
  import ipc_doorbell_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  hst_addr,
  input  logic [DATA_W-1:0] hst_wdata,
  input  logic              hst_we,
  output logic [DATA_W-1:0] hst_rdata,
  input  logic [SEL_W-1:0]  dsp_addr,
  input  logic [DATA_W-1:0] dsp_wdata,
  input  logic              dsp_we,
  output logic [DATA_W-1:0] dsp_rdata,
  output logic              host_irq,
  output logic              dsp_doorbell
);
  localparam int DONE_B = DATA_W - 2;

  logic              srst_n;
  logic              ini_busy, ini_done, ovr, tgt_busy, tgt_ack;
  logic [DATA_W-2:0] ini_pay, tgt_pay;
  logic [DATA_W-1:0] ini_ext, tgt_ext;
  logic [DATA_W-1:0] ini_pri_w, ini_ack_w, tgt_pri_w, tgt_ack_w, ctrl_w;
  logic              en_busy_q, en_done_q, en_busy_d, en_done_d, ctrl_we;
  reg_sel_e          h_sel, d_sel;

  assign h_sel   = reg_sel_e'(hst_addr);
  assign d_sel   = reg_sel_e'(dsp_addr);
  assign ctrl_we = hst_we && (h_sel == SEL_CTRL);

  dbl_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .srst_n(srst_n)
  );

  dbl_ini_lane #(.DATA_W(DATA_W)) u_ini (
    .clk(clk), .rst_n(srst_n),
    .h_pri_we(hst_we && (h_sel == SEL_INI_PRI)),
    .h_ext_we(hst_we && (h_sel == SEL_INI_EXT)),
    .h_ack_we(hst_we && (h_sel == SEL_INI_ACK)),
    .h_wdata(hst_wdata),
    .d_ack_we(dsp_we && (d_sel == SEL_INI_ACK)),
    .d_wdata(dsp_wdata),
    .ovr_clr(ctrl_we && hst_wdata[CTRL_OVR]),
    .busy_o(ini_busy), .done_o(ini_done), .ovr_o(ovr),
    .pay_o(ini_pay), .ext_o(ini_ext)
  );

  dbl_tgt_lane #(.DATA_W(DATA_W)) u_tgt (
    .clk(clk), .rst_n(srst_n),
    .d_pri_we(dsp_we && (d_sel == SEL_TGT_PRI)),
    .d_ext_we(dsp_we && (d_sel == SEL_TGT_EXT)),
    .d_wdata(dsp_wdata),
    .h_pri_we(hst_we && (h_sel == SEL_TGT_PRI)),
    .h_ack_we(hst_we && (h_sel == SEL_TGT_ACK)),
    .h_wdata(hst_wdata),
    .busy_o(tgt_busy), .ack_o(tgt_ack),
    .pay_o(tgt_pay), .ext_o(tgt_ext)
  );

  always_comb begin
    en_busy_d = en_busy_q;
    en_done_d = en_done_q;
    if (ctrl_we) begin
      en_busy_d = hst_wdata[CTRL_EN_BUSY];
      en_done_d = hst_wdata[CTRL_EN_DONE];
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      en_busy_q <= 1'b0;
      en_done_q <= 1'b0;
    end else begin
      en_busy_q <= en_busy_d;
      en_done_q <= en_done_d;
    end
  end

  always_comb begin
    ini_pri_w = {ini_busy, ini_pay};
    tgt_pri_w = {tgt_busy, tgt_pay};
    ini_ack_w = '0;
    ini_ack_w[DONE_B] = ini_done;
    tgt_ack_w = '0;
    tgt_ack_w[DATA_W-1] = tgt_ack;
    ctrl_w = '0;
    ctrl_w[CTRL_EN_BUSY] = en_busy_q;
    ctrl_w[CTRL_EN_DONE] = en_done_q;
    ctrl_w[CTRL_OVR]     = ovr;
  end

  always_comb begin
    unique case (h_sel)
      SEL_INI_PRI: hst_rdata = ini_pri_w;
      SEL_INI_EXT: hst_rdata = ini_ext;
      SEL_INI_ACK: hst_rdata = ini_ack_w;
      SEL_TGT_PRI: hst_rdata = tgt_pri_w;
      SEL_TGT_EXT: hst_rdata = tgt_ext;
      SEL_TGT_ACK: hst_rdata = tgt_ack_w;
      SEL_CTRL:    hst_rdata = ctrl_w;
      default:     hst_rdata = '0;
    endcase
  end

  always_comb begin
    unique case (d_sel)
      SEL_INI_PRI: dsp_rdata = ini_pri_w;
      SEL_INI_EXT: dsp_rdata = ini_ext;
      SEL_INI_ACK: dsp_rdata = ini_ack_w;
      SEL_TGT_PRI: dsp_rdata = tgt_pri_w;
      SEL_TGT_EXT: dsp_rdata = tgt_ext;
      SEL_TGT_ACK: dsp_rdata = tgt_ack_w;
      default:     dsp_rdata = '0;
    endcase
  end

  assign host_irq     = (tgt_busy && en_busy_q) || (ini_done && en_done_q);
  assign dsp_doorbell = ini_busy;
endmodule

// File: rtl/ipc_doorbell_chk.sv
module ipc_doorbell_chk
  import ipc_doorbell_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              srst_n,
  input logic [SEL_W-1:0]  hst_addr,
  input logic [DATA_W-1:0] hst_wdata,
  input logic              hst_we,
  input logic [SEL_W-1:0]  dsp_addr,
  input logic [DATA_W-1:0] dsp_wdata,
  input logic              dsp_we,
  input logic              host_irq,
  input logic              dsp_doorbell,
  input logic              tgt_busy,
  input logic              tgt_ack,
  input logic              ovr
);
  localparam int B = DATA_W - 1;
  localparam int D = DATA_W - 2;

  p_send_rings_r2: assert property (@(posedge clk) disable iff (!srst_n)
    (hst_we && hst_addr == SEL_INI_PRI && hst_wdata[B] && !dsp_doorbell) |=> dsp_doorbell);

  p_overrun_sticky_r3: assert property (@(posedge clk) disable iff (!srst_n)
    (hst_we && hst_addr == SEL_INI_PRI && hst_wdata[B] && dsp_doorbell) |=> ovr);

  p_done_frees_r4: assert property (@(posedge clk) disable iff (!srst_n)
    (dsp_we && dsp_addr == SEL_INI_ACK && dsp_wdata[D] && !(hst_we && hst_addr == SEL_INI_PRI))
    |=> !dsp_doorbell);

  p_tgt_post_r5: assert property (@(posedge clk) disable iff (!srst_n)
    (dsp_we && dsp_addr == SEL_TGT_PRI && dsp_wdata[B] && !tgt_busy) |=> (tgt_busy && tgt_ack));

  p_tgt_accept_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (hst_we && hst_addr == SEL_TGT_PRI && hst_wdata[B] && !(dsp_we && dsp_addr == SEL_TGT_PRI))
    |=> !tgt_busy);

  p_irq_cause_r8: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(host_irq) |-> $past(hst_we || dsp_we));
endmodule

bind ipc_doorbell ipc_doorbell_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .srst_n(srst_n),
  .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_we(hst_we),
  .dsp_addr(dsp_addr), .dsp_wdata(dsp_wdata), .dsp_we(dsp_we),
  .host_irq(host_irq), .dsp_doorbell(dsp_doorbell),
  .tgt_busy(tgt_busy), .tgt_ack(tgt_ack), .ovr(ovr)
);

// File: tb/ipc_doorbell_test.sv
`timescale 1ns/1ps
module ipc_doorbell_test;
  localparam logic [31:0] BSY = 32'h8000_0000;
  localparam logic [31:0] DN  = 32'h4000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  hst_addr = '0, dsp_addr = '0;
  logic [31:0] hst_wdata = '0, dsp_wdata = '0;
  logic        hst_we = 1'b0, dsp_we = 1'b0;
  logic [31:0] hst_rdata, dsp_rdata;
  logic        host_irq, dsp_doorbell;
  int          n_chk = 0, n_fail = 0;
  bit          finished = 0;

  always #4 clk = ~clk;

  ipc_doorbell uut (
    .clk(clk), .rst_n(rst_n),
    .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_we(hst_we), .hst_rdata(hst_rdata),
    .dsp_addr(dsp_addr), .dsp_wdata(dsp_wdata), .dsp_we(dsp_we), .dsp_rdata(dsp_rdata),
    .host_irq(host_irq), .dsp_doorbell(dsp_doorbell)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic both_wr(input logic hw, input logic [2:0] ha, input logic [31:0] hd,
                         input logic dw, input logic [2:0] da, input logic [31:0] dd);
    @(negedge clk);
    hst_we = hw; hst_addr = ha; hst_wdata = hd;
    dsp_we = dw; dsp_addr = da; dsp_wdata = dd;
    @(negedge clk);
    hst_we = 1'b0; dsp_we = 1'b0;
  endtask

  task automatic hwr(input logic [2:0] a, input logic [31:0] d);
    both_wr(1'b1, a, d, 1'b0, 3'd0, 32'h0);
  endtask

  task automatic dwr(input logic [2:0] a, input logic [31:0] d);
    both_wr(1'b0, 3'd0, 32'h0, 1'b1, a, d);
  endtask

  task automatic hrd(input logic [2:0] a, output logic [31:0] d);
    hst_addr = a; #1; d = hst_rdata;
  endtask

  task automatic drd(input logic [2:0] a, output logic [31:0] d);
    dsp_addr = a; #1; d = dsp_rdata;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] r, pat, ext, d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state on both ports
    for (int a = 0; a < 8; a++) begin
      hrd(3'(a), r); chk("R1 host reg", r, 32'h0);
      drd(3'(a), r); chk("R1 dsp reg", r, 32'h0);
    end
    chk("R1 irq", {31'h0, host_irq}, 32'h0);
    chk("R1 doorbell", {31'h0, dsp_doorbell}, 32'h0);

    // R2 / R4 sweep of payload patterns through the initiator path
    for (int i = 0; i < 8; i++) begin
      pat = 32'h1234_5678 ^ (32'(i) * 32'h0901_0301);
      ext = ~pat ^ 32'(i);
      hwr(3'd1, ext);
      hwr(3'd0, pat | BSY);
      chk("R2 doorbell", {31'h0, dsp_doorbell}, 32'h1);
      drd(3'd0, r); chk("R2 dsp primary", r, pat | BSY);
      drd(3'd1, r); chk("R2 dsp extension", r, ext);
      dwr(3'd2, DN);
      hrd(3'd0, r); chk("R4 busy cleared", r, pat & ~BSY);
      hrd(3'd2, r); chk("R4 done set", r, DN);
      hwr(3'd2, 32'h0);
      hrd(3'd2, r); chk("R4 zero write keeps done", r, DN);
      hwr(3'd2, DN);
      hrd(3'd2, r); chk("R4 done cleared", r, 32'h0);
    end
    hwr(3'd0, 32'h0000_0055);
    hrd(3'd0, r); chk("R2 write without busy ignored", r, pat & ~BSY);
    chk("R2 doorbell stays low", {31'h0, dsp_doorbell}, 32'h0);

    // R3 overrun
    hwr(3'd1, 32'hAAAA_0001);
    hwr(3'd0, BSY | 32'h0000_0123);
    hwr(3'd0, BSY | 32'h0000_0456);
    hwr(3'd1, 32'h5555_0002);
    hrd(3'd0, r); chk("R3 payload kept", r, BSY | 32'h0000_0123);
    hrd(3'd1, r); chk("R3 extension kept", r, 32'hAAAA_0001);
    hrd(3'd6, r); chk("R3 overrun set", r, 32'h4);
    dwr(3'd2, DN);
    hrd(3'd6, r); chk("R3 overrun sticky", r, 32'h4);
    hwr(3'd6, 32'h4);
    hrd(3'd6, r); chk("R3 overrun cleared", r, 32'h0);

    // R4 same-cycle set and clear of DONE: set wins
    hwr(3'd2, DN);
    both_wr(1'b1, 3'd2, DN, 1'b1, 3'd2, DN);
    hrd(3'd2, r); chk("R4 dsp set wins", r, DN);
    hwr(3'd2, DN);

    // R5 R6 R7 target path, direction bit 29 both ways
    for (int i = 0; i < 4; i++) begin
      d = BSY | (32'(i & 1) << 29) | (32'(i) * 32'h0011_0105);
      ext = 32'hC0DE_0000 | 32'(i);
      dwr(3'd4, ext);
      dwr(3'd3, d);
      hrd(3'd3, r); chk("R5 target primary", r, d);
      hrd(3'd4, r); chk("R5 target extension", r, ext);
      hrd(3'd5, r); chk("R5 target ack set", r, BSY);
      dwr(3'd3, BSY | 32'h0F0F_0F0F);
      dwr(3'd4, 32'h1111_1111);
      hrd(3'd3, r); chk("R5 primary write ignored while busy", r, d);
      hrd(3'd4, r); chk("R5 extension write ignored while busy", r, ext);
      hwr(3'd3, 32'h0);
      hrd(3'd3, r); chk("R6 zero write no effect", r, d);
      hwr(3'd3, BSY);
      hrd(3'd3, r); chk("R6 busy cleared", r, d & ~BSY);
      hwr(3'd5, BSY);
      drd(3'd5, r); chk("R7 one write no effect", r, BSY);
      hwr(3'd5, 32'h0);
      drd(3'd5, r); chk("R7 dsp sees ack cleared", r, 32'h0);
      hrd(3'd5, r); chk("R7 host sees ack cleared", r, 32'h0);
    end

    // R8 sweep: every enable pair against every pending event pair
    for (int en = 0; en < 4; en++) begin
      for (int ev = 0; ev < 4; ev++) begin
        hwr(3'd6, 32'(en));
        hrd(3'd6, r); chk("R8 control readback", r, 32'(en));
        if (ev[0]) dwr(3'd3, BSY | 32'(ev));
        if (ev[1]) dwr(3'd2, DN);
        chk("R8 irq", {31'h0, host_irq},
            {31'h0, (ev[0] & en[0]) | (ev[1] & en[1])});
        hwr(3'd6, 32'h0);
        hwr(3'd3, BSY);
        hwr(3'd5, 32'h0);
        hwr(3'd2, DN);
        chk("R8 irq idle", {31'h0, host_irq}, 32'h0);
      end
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule